// File: doc/BRIEF.md
# Battery Monitor Power-Mode Sequencer

This block decides when a battery monitor wakes up to measure, compute and take protection decisions. It keeps the monitor in one of three power modes: run (a measurement every second), doze (a measurement every few seconds, set by an 8-bit interval register) and off (no activity at all). All timing comes from a 32.768 kHz tick that arrives as a one-cycle enable pulse on the system clock. Mode changes happen only on tick cycles.

Doze ends when the current-wake comparator fires or when a fault is flagged. Either event is latched and brings the monitor back to run on the next tick, with an immediate measurement. Off is left only when the pack-voltage-present input is high on a tick. The block also converts the wake-level bit and the two sense-range bits into a 2-bit threshold code for the analog comparator. On every measurement strobe it samples the active-low host-present pin. All inputs and outputs are plain level signals. No data stream passes through the block, so no valid/ready handshake is used.

Top module: `pms_power_sequencer`

## Requirements
- R1: During and after reset, `mode_o` is 00 (run), and `meas_strobe_o`, `host_present_o` and `wake_code_o` are all 0.
- R2: In run mode, `meas_strobe_o` is high for exactly one clock. It rises one clock after the tick that completes each group of TICKS_PER_SEC ticks.
- R3: In run mode, a tick with `sleep_req_i` high moves the mode to 01 (doze), unless `fault_i` is high in that tick. `shutdown_req_i` has priority over `sleep_req_i`.
- R4: In doze, a strobe fires once every N seconds, where N is `sleep_interval_i`. A value of 0 counts as 1.
- R5: In doze, a one-cycle pulse on `wake_cmp_i` or `fault_i` in any clock is remembered. The next tick returns the mode to 00, and a strobe fires in that same update.
- R6: A tick with `shutdown_req_i` high in run or doze moves the mode to 10 (off). While off, no strobe fires, and `wake_cmp_i`, `fault_i` and `sleep_req_i` have no effect.
- R7: Off is left only on a tick with `pack_present_i` high. That tick moves the mode to 00 and fires a strobe.
- R8: `wake_code_o` takes one clock to follow its inputs. With range r = `sense_range_i` and level l = `wake_level_i`: if r = 0 the code is 0; otherwise it is min(r + l - 1, 3). Code 00 means 1.0 mV, 01 means 2.25 mV, 10 means 4.5 mV and 11 means 9 mV.
- R9: In each strobe update, `host_present_o` takes the inverse of `host_pres_n_i`. Between strobes it holds its value.
- R10: Every mode change restarts the one-second count. The first run-mode strobe after a return from doze comes exactly TICKS_PER_SEC ticks after the strobe that marked the return.
- R11: `mode_o` and `meas_strobe_o` change only in the clock after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at 32.768 kHz |
| wake_cmp_i | input | 1 | Current-wake comparator output |
| fault_i | input | 1 | Fault flag from protection logic |
| sleep_req_i | input | 1 | Command to enter doze |
| shutdown_req_i | input | 1 | Command to enter off |
| pack_present_i | input | 1 | Pack voltage at startup threshold |
| host_pres_n_i | input | 1 | Host-present pin, low means host present |
| sleep_interval_i | input | INTERVAL_W | Doze measurement interval in seconds |
| wake_level_i | input | 1 | Wake-level select bit |
| sense_range_i | input | 2 | Sense-range select bits |
| mode_o | output | 2 | 00 run, 01 doze, 10 off |
| meas_strobe_o | output | 1 | One-cycle measure-and-protect strobe |
| wake_code_o | output | 2 | Wake-threshold code |
| host_present_o | output | 1 | Latched host-present state |

## Verification
Faults inside this block show up in three places at the ports: a wrong mode encoding, a missing or extra strobe, or a strobe at the wrong time. The bench model compares every output on every clock, so an error in the tick counter shows up within one second of ticks. An error in the doze divider shows up at the first doze strobe. A lost wake latch or a wrong off-mode exit shows up as a missing mode change one tick after the stimulus. A threshold-encoding error shows up one clock after the select bits change.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_DOZE = 2'b01,
    PM_OFF  = 2'b10
  } pm_mode_e;

  // Threshold code: range 0 forces the lowest code, otherwise range+level-1
  // saturated at 3 (00=1.0mV, 01=2.25mV, 10=4.5mV, 11=9mV).
  function automatic logic [1:0] wake_code_f(input logic lvl, input logic [1:0] rng);
    logic [2:0] sum;
    sum = {1'b0, rng} + {2'b00, lvl};
    if (rng == 2'b00)       return 2'b00;
    else if (sum >= 3'd4)   return 2'b11;
    else                    return 2'(sum - 3'd1);
  endfunction

endpackage

// File: rtl/pms_second_timer.sv
`timescale 1ns/1ps
module pms_second_timer #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic sec_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_o = tick_i & run_i & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i || !run_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // The count restarts after each completed second.
  assert_sec_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o |=> (cnt_q == '0));

endmodule

// File: rtl/pms_doze_divider.sv
`timescale 1ns/1ps
module pms_doze_divider #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          adv_i,
  input  logic [IW-1:0] interval_i,
  output logic          due_o
);
  localparam int EW = IW + 1;

  logic [IW-1:0] cnt_q;
  logic [EW-1:0] eff;
  logic [EW-1:0] nxt;

  assign eff   = (interval_i == '0) ? EW'(1) : {1'b0, interval_i};
  assign nxt   = {1'b0, cnt_q} + EW'(1);
  assign due_o = adv_i & (nxt >= eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (adv_i)  cnt_q <= due_o ? '0 : cnt_q + 1'b1;
  end

  // A due second restarts the doze count.
  assert_doze_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (due_o && !hold_i) |=> (cnt_q == '0));

endmodule

// File: rtl/pms_wake_code_reg.sv
`timescale 1ns/1ps
module pms_wake_code_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic [1:0] range_i,
  output logic [1:0] code_o
);
  import pms_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_o <= 2'b00;
    else        code_o <= wake_code_f(level_i, range_i);
  end

endmodule

// File: rtl/pms_power_sequencer.sv
`timescale 1ns/1ps
module pms_power_sequencer #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int INTERVAL_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wake_cmp_i,
  input  logic                  fault_i,
  input  logic                  sleep_req_i,
  input  logic                  shutdown_req_i,
  input  logic                  pack_present_i,
  input  logic                  host_pres_n_i,
  input  logic [INTERVAL_W-1:0] sleep_interval_i,
  input  logic                  wake_level_i,
  input  logic [1:0]            sense_range_i,
  output logic [1:0]            mode_o,
  output logic                  meas_strobe_o,
  output logic [1:0]            wake_code_o,
  output logic                  host_present_o
);
  import pms_pkg::*;

  pm_mode_e mode_q, mode_n;
  logic     fire;
  logic     sec_evt;
  logic     doze_due;
  logic     pend_q;
  logic     exit_wake;
  logic     strobe_q;
  logic     host_q;
  logic     restart;
  logic     doze_adv;
  logic     in_doze;

  assign in_doze   = (mode_q == PM_DOZE);
  assign exit_wake = pend_q | wake_cmp_i | fault_i;
  assign restart   = tick_i & (mode_n != mode_q);
  assign doze_adv  = sec_evt & in_doze & ~exit_wake & ~shutdown_req_i;

  pms_second_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .run_i   (mode_q != PM_OFF),
    .clear_i (restart),
    .sec_o   (sec_evt)
  );

  pms_doze_divider #(.IW(INTERVAL_W)) u_doze (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (~in_doze),
    .adv_i      (doze_adv),
    .interval_i (sleep_interval_i),
    .due_o      (doze_due)
  );

  pms_wake_code_reg u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (wake_level_i),
    .range_i (sense_range_i),
    .code_o  (wake_code_o)
  );

  // Next-mode and strobe decision, evaluated only on tick cycles.
  always_comb begin
    mode_n = mode_q;
    fire   = 1'b0;
    if (tick_i) begin
      unique case (mode_q)
        PM_RUN: begin
          if (shutdown_req_i)               mode_n = PM_OFF;
          else if (sleep_req_i && !fault_i) mode_n = PM_DOZE;
          else if (sec_evt)                 fire   = 1'b1;
        end
        PM_DOZE: begin
          if (exit_wake) begin
            mode_n = PM_RUN;
            fire   = 1'b1;
          end else if (shutdown_req_i) begin
            mode_n = PM_OFF;
          end else if (doze_due) begin
            fire   = 1'b1;
          end
        end
        PM_OFF: begin
          if (pack_present_i) begin
            mode_n = PM_RUN;
            fire   = 1'b1;
          end
        end
        default: mode_n = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_RUN;
      strobe_q <= 1'b0;
      host_q   <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      strobe_q <= fire;
      if (fire) host_q <= ~host_pres_n_i;
    end
  end

  // Wake/fault seen during doze is held until the mode leaves doze.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_q <= 1'b0;
    else if (!in_doze)             pend_q <= 1'b0;
    else if (wake_cmp_i | fault_i) pend_q <= 1'b1;
  end

  assign mode_o         = mode_q;
  assign meas_strobe_o  = strobe_q;
  assign host_present_o = host_q;

  assert_strobe_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    meas_strobe_o |-> $past(tick_i));

  assert_mode_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(tick_i));

  assert_off_exit_needs_pack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == PM_OFF && mode_q != PM_OFF) |-> $past(pack_present_i));

  assert_doze_return_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == PM_DOZE && mode_q == PM_RUN) |-> meas_strobe_o);

  assert_off_is_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_OFF) |-> !meas_strobe_o);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_strobe_o |=> !meas_strobe_o);

endmodule

// File: tb/pms_power_sequencer_test.sv
`timescale 1ns/1ps
module pms_power_sequencer_test;
  localparam int TPS = 4;
  localparam int IW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic wake_cmp_i = 1'b0, fault_i = 1'b0, sleep_req_i = 1'b0;
  logic shutdown_req_i = 1'b0, pack_present_i = 1'b0, host_pres_n_i = 1'b1;
  logic [IW-1:0] sleep_interval_i = 8'd3;
  logic wake_level_i = 1'b0;
  logic [1:0] sense_range_i = 2'd1;
  logic [1:0] mode_o, wake_code_o;
  logic meas_strobe_o, host_present_o;

  int n_tests = 0, n_fail = 0, cyc = 0, div = 0;
  bit done = 0, cmp_en = 0;

  pms_power_sequencer #(.TICKS_PER_SEC(TPS), .INTERVAL_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wake_cmp_i(wake_cmp_i),
    .fault_i(fault_i), .sleep_req_i(sleep_req_i), .shutdown_req_i(shutdown_req_i),
    .pack_present_i(pack_present_i), .host_pres_n_i(host_pres_n_i),
    .sleep_interval_i(sleep_interval_i), .wake_level_i(wake_level_i),
    .sense_range_i(sense_range_i), .mode_o(mode_o), .meas_strobe_o(meas_strobe_o),
    .wake_code_o(wake_code_o), .host_present_o(host_present_o));

  always #5 clk = ~clk;

  // Tick every third clock.
  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    tick_i = (div == 0);
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  int m_mode = 0, m_str = 0, m_host = 0, m_code = 0, sub = 0, slp = 0, pend = 0, prev_tick = 0;

  function automatic int ref_code(int lvl, int rng);
    int c;
    if (rng == 0) return 0;
    c = rng + lvl - 1;
    return (c > 3) ? 3 : c;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (!rst_n) begin
      m_mode = 0; m_str = 0; m_host = 0; m_code = 0; sub = 0; slp = 0; pend = 0;
    end else begin
      int nxt, str, sec, eff;
      m_code = ref_code(int'(wake_level_i), int'(sense_range_i));
      str = 0;
      nxt = m_mode;
      if (tick_i) begin
        sec = (m_mode != 2) && (sub == TPS - 1);
        eff = (sleep_interval_i == 0) ? 1 : int'(sleep_interval_i);
        if (m_mode == 0) begin
          if (shutdown_req_i) nxt = 2;
          else if (sleep_req_i && !fault_i) nxt = 1;
          else if (sec) str = 1;
        end else if (m_mode == 1) begin
          if (pend || wake_cmp_i || fault_i) begin nxt = 0; str = 1; end
          else if (shutdown_req_i) nxt = 2;
          else if (sec) begin
            slp++;
            if (slp >= eff) begin str = 1; slp = 0; end
          end
        end else begin
          if (pack_present_i) begin nxt = 0; str = 1; end
        end
        if (nxt != m_mode) begin sub = 0; slp = 0; pend = 0; end
        else if (m_mode != 2) sub = sec ? 0 : sub + 1;
        m_mode = nxt;
        if (str) m_host = host_pres_n_i ? 0 : 1;
      end else if (m_mode == 1 && (wake_cmp_i || fault_i)) begin
        pend = 1;
      end
      m_str = str;
    end
    prev_tick = tick_i;
  end

  // Per-clock comparison.
  int last_mode = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 mode", int'(mode_o), m_mode);
      chk("R2 strobe", int'(meas_strobe_o), m_str);
      chk("R8 wake code", int'(wake_code_o), m_code);
      chk("R9 host", int'(host_present_o), m_host);
      if (int'(mode_o) != last_mode) chk("R11 mode change after tick", prev_tick, 1);
      last_mode = int'(mode_o);
    end
  end

  task automatic wait_mode(int m, output int n);
    n = 0;
    while (int'(mode_o) != m && n < 600) begin @(negedge clk); n++; end
  endtask

  task automatic count_strobes(int len, output int s);
    s = 0;
    for (int i = 0; i < len; i++) begin @(negedge clk); if (meas_strobe_o) s++; end
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!meas_strobe_o && n < 2000);
  endtask

  initial begin
    int n, s;
    repeat (4) @(negedge clk);
    chk("R1 reset mode", int'(mode_o), 0);
    chk("R1 reset strobe", int'(meas_strobe_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 host after reset", int'(host_present_o), 0);
    chk("R1 mode after reset", int'(mode_o), 0);
    cmp_en = 1;

    // R2: ten seconds of run mode give ten strobes.
    repeat (5) @(negedge clk);
    count_strobes(12 * 10, s);
    chk("R2 run strobes in 10 s", s, 10);

    // R8: all select combinations.
    for (int l = 0; l < 2; l++)
      for (int r = 0; r < 4; r++) begin
        wake_level_i = l[0]; sense_range_i = r[1:0];
        repeat (2) @(negedge clk);
        chk("R8 code", int'(wake_code_o), (r == 0) ? 0 : ((r + l - 1 > 3) ? 3 : r + l - 1));
      end

    // R9: host sampled at strobes only.
    host_pres_n_i = 1'b0;
    wait_strobe(n);
    chk("R9 host at strobe", int'(host_present_o), 1);
    host_pres_n_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 host held", int'(host_present_o), 1);
    wait_strobe(n);
    chk("R9 host cleared at strobe", int'(host_present_o), 0);

    // R3: fault blocks doze entry.
    fault_i = 1'b1; sleep_req_i = 1'b1;
    repeat (30) @(negedge clk);
    chk("R3 fault blocks doze", int'(mode_o), 0);
    fault_i = 1'b0;
    wait_mode(1, n);
    sleep_req_i = 1'b0;
    chk("R3 doze entered", int'(mode_o), 1);

    // R4: interval 3 and interval 0.
    sleep_interval_i = 8'd3;
    count_strobes(36 * 4, s);
    chk("R4 interval 3 strobes", s, 4);
    sleep_interval_i = 8'd0;
    wait_strobe(n);
    count_strobes(12 * 5, s);
    chk("R4 interval 0 strobes", s, 5);

    // R5 and R10: wake pulse returns to run, then a full second.
    sleep_interval_i = 8'd255;
    repeat (7) @(negedge clk);
    wake_cmp_i = 1'b1; @(negedge clk); wake_cmp_i = 1'b0;
    wait_mode(0, n);
    chk("R5 wake return within a tick", int'(n <= 3), 1);
    chk("R5 strobe on return", int'(meas_strobe_o), 1);
    wait_strobe(n);
    chk("R10 first run strobe after return", n, 12);

    // R5: fault pulse in doze.
    sleep_req_i = 1'b1; wait_mode(1, n); sleep_req_i = 1'b0;
    repeat (4) @(negedge clk);
    fault_i = 1'b1; @(negedge clk); fault_i = 1'b0;
    wait_mode(0, n);
    chk("R5 fault return", int'(mode_o), 0);
    chk("R5 fault return strobe", int'(meas_strobe_o), 1);

    // R6: off mode ignores wake, fault and doze request.
    shutdown_req_i = 1'b1; sleep_req_i = 1'b1;
    wait_mode(2, n);
    shutdown_req_i = 1'b0;
    chk("R6 shutdown priority", int'(mode_o), 2);
    wake_cmp_i = 1'b1; fault_i = 1'b1;
    count_strobes(50, s);
    wake_cmp_i = 1'b0; fault_i = 1'b0; sleep_req_i = 1'b0;
    chk("R6 no strobe while off", s, 0);
    chk("R6 still off", int'(mode_o), 2);

    // R7: pack input leaves off.
    pack_present_i = 1'b1;
    wait_mode(0, n);
    chk("R7 pack exit strobe", int'(meas_strobe_o), 1);
    pack_present_i = 1'b0;

    // R6/R7: off from doze, then exit again.
    sleep_req_i = 1'b1; wait_mode(1, n); sleep_req_i = 1'b0;
    shutdown_req_i = 1'b1; wait_mode(2, n); shutdown_req_i = 1'b0;
    chk("R6 doze to off", int'(mode_o), 2);
    repeat (20) @(negedge clk);
    chk("R7 stays off without pack", int'(mode_o), 2);
    pack_present_i = 1'b1; wait_mode(0, n); pack_present_i = 1'b0;
    chk("R7 exit to run", int'(mode_o), 0);
    repeat (30) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule